// File: doc/BRIEF.md
# Channel-List Sample Sequencer with Tagged Result FIFO

This block steps an analog-to-digital converter front end through a programmable list of input channels. Software loads a list of up to eight 3-bit channel selects and a last-index field, sets the gap between conversions, and then writes a start command. The sequencer issues one conversion request per list entry. Each returned 12-bit code is stored in a result FIFO together with the channel that produced it, so the reader never has to infer which input a word came from.

One pass covers the list once and then stops. Continuous mode wraps back to the first entry and keeps running until software halts it. Control, configuration, status and FIFO reads all go through a small register port. The converter sits behind a request/acknowledge handshake.

Top module: `sample_sequencer`

## Requirements
- R1: After reset the engine is idle (status bit 0 low), conv_req is low, the FIFO is empty (status bit 4 high), full (bit 3), overflow (bit 5) and the count field are zero.
- R2: A write to the control register (address 0) starts a run only when it carries both start (bit 2) and enable (bit 0). A start written with enable low leaves the engine idle and issues no request.
- R3: A run requests list entries 0 through the last index in order. Entry n occupies bits 3n+2:3n of the list register (address 1) and the last index sits at bits 26:24, where 0 means one entry. Without continuous mode the engine goes idle after the last entry.
- R4: With continuous mode (control bit 1) set, the walk wraps from the last index back to entry 0 and continues.
- R5: Each completed conversion enters the FIFO as one word, with the channel select at bits 14:12 and the code at bits 11:0. Words leave in arrival order.
- R6: The status register (address 0 read) carries a 3-bit busy field at bits 2:0. Bit 0 is high while a run is active and bits 2:1 read zero. It also carries full at bit 3, empty at bit 4, overflow at bit 5, and the occupancy modulo the FIFO depth starting at bit 8.
- R7: A read of address 3 returns the oldest word and removes it. A read of an empty FIFO returns zero and leaves the count unchanged.
- R8: A result that arrives while the FIFO is full is discarded and sets the overflow flag. The flag stays set until a control write with bit 4 set clears it.
- R9: Between an acknowledge and the next request the engine waits (D+1)·2^(S·STEP) cycles. D is bits 7:0 of the pace register (address 2), S is bits 9:8, and STEP is a parameter.
- R10: A stop (control bit 3, or any control write with enable low) ends a run. If it arrives during the wait between conversions, the engine is idle on the next cycle. If it arrives while a request is outstanding, that conversion completes and is stored, and then the engine goes idle.
- R11: A start written while a run is active is ignored. The list walk continues from where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the FIFO at address 3 |
| reg_addr | input | 2 | Register select: 0 control/status, 1 list, 2 pace, 3 FIFO |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| conv_req | output | 1 | Conversion request, held until acknowledged |
| conv_chan | output | 3 | Channel select for the pending request |
| conv_ack | input | 1 | One-cycle conversion done |
| conv_code | input | 12 | Conversion result, valid with conv_ack |

## Verification
The bench builds the block with an 8-deep FIFO and a pace step of 1. With that depth, one full list pass fills the FIFO exactly, and a short second pass then pushes it into overflow. The small step keeps every pace select within a few dozen cycles, so the measured gap can be compared exactly with the formula. Stop is exercised during a pending request, during a pace wait and through a cleared enable bit. A restart attempt is made mid-run.

// File: rtl/seqr_pkg.sv
`timescale 1ns/1ps
package seqr_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LIST = 2'd1;
    localparam logic [1:0] ADDR_PACE = 2'd2;
    localparam logic [1:0] ADDR_FIFO = 2'd3;

    localparam int C_EN    = 0;
    localparam int C_CONT  = 1;
    localparam int C_START = 2;
    localparam int C_STOP  = 3;
    localparam int C_CLR   = 4;

    localparam int S_BUSY  = 0;
    localparam int S_FULL  = 3;
    localparam int S_EMPTY = 4;
    localparam int S_OVF   = 5;
    localparam int S_CNT   = 8;

    localparam int L_LAST  = 24;
    localparam int P_SEL   = 8;
endpackage

// File: rtl/seq_fifo.sv
`timescale 1ns/1ps
module seq_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          clr_ovf,
    output logic [W-1:0]  head,
    output logic [$clog2(DEPTH):0] count,
    output logic          full,
    output logic          empty,
    output logic          ovf
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] CNT_FULL = (PW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [PW:0]             cnt;
        logic                    ovf;
    } fifo_s;

    fifo_s s_d, s_q;
    logic do_pop, do_push;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && ((s_q.cnt != CNT_FULL) || do_pop);
        if (do_push) begin
            s_d.mem[s_q.wp] = push_data;
            s_d.wp          = s_q.wp + 1'b1;
        end
        if (do_pop)
            s_d.rp = s_q.rp + 1'b1;
        s_d.cnt = s_q.cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        if (clr_ovf)
            s_d.ovf = 1'b0;
        if (push && !do_push)
            s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == CNT_FULL);
    assign empty = (s_q.cnt == '0);
    assign ovf   = s_q.ovf;

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_FULL);
    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (s_q.cnt == '0));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !clr_ovf) |=> s_q.ovf);
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (full && s_q.ovf));
endmodule

// File: rtl/seq_pace.sv
`timescale 1ns/1ps
module seq_pace #(
    parameter int DLY_W = 8,
    parameter int SEL_W = 2,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    localparam int TW = DLY_W + 1 + ((1 << SEL_W) - 1) * STEP;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } pace_s;

    pace_s s_d, s_q;
    logic [TW-1:0] span;

    always_comb begin
        s_d  = s_q;
        span = (TW'(dly) + TW'(1)) << (sel * STEP);
        if (load)
            s_d.cnt = span - TW'(1);
        else if (s_q.cnt != '0)
            s_d.cnt = s_q.cnt - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done = (s_q.cnt == '0);

    p_pace_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - TW'(1)));
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
    import seqr_pkg::*;
#(
    parameter int LIST_LEN = 8,
    parameter int CH_W     = 3,
    parameter int SMP_W    = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     stop,
    input  logic                     cont,
    input  logic [LIST_LEN*CH_W-1:0] list,
    input  logic [$clog2(LIST_LEN)-1:0] last_idx,
    input  logic                     pace_done,
    input  logic                     conv_ack,
    input  logic [SMP_W-1:0]         conv_code,
    output logic                     conv_req,
    output logic [CH_W-1:0]          conv_chan,
    output logic                     busy,
    output logic                     pace_load,
    output logic                     push,
    output logic [CH_W+SMP_W-1:0]    push_data
);
    localparam int IDX_W = $clog2(LIST_LEN);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             stop_pend;
    } ctrl_s;

    ctrl_s s_d, s_q;

    always_comb begin
        s_d       = s_q;
        pace_load = 1'b0;
        push      = 1'b0;
        conv_chan = list[s_q.idx*CH_W +: CH_W];
        case (s_q.state)
            ST_IDLE: begin
                if (start && !stop) begin
                    s_d.state     = ST_REQ;
                    s_d.idx       = '0;
                    s_d.stop_pend = 1'b0;
                end
            end
            ST_REQ: begin
                if (stop)
                    s_d.stop_pend = 1'b1;
                if (conv_ack) begin
                    push = 1'b1;
                    if (stop || s_q.stop_pend) begin
                        s_d.state = ST_IDLE;
                    end else if (s_q.idx == last_idx && !cont) begin
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.idx   = (s_q.idx == last_idx) ? '0 : s_q.idx + 1'b1;
                        s_d.state = ST_WAIT;
                        pace_load = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (stop)
                    s_d.state = ST_IDLE;
                else if (pace_done)
                    s_d.state = ST_REQ;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, idx: '0, stop_pend: 1'b0};
        else        s_q <= s_d;
    end

    assign conv_req  = (s_q.state == ST_REQ);
    assign busy      = (s_q.state != ST_IDLE);
    assign push_data = {conv_chan, conv_code};

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_ack) |=> (conv_req && $stable(conv_chan)));
    p_stop_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAIT && stop) |=> (s_q.state == ST_IDLE));
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAIT && start && !stop && !pace_done) |=> (s_q.state == ST_WAIT));
endmodule

// File: rtl/sample_sequencer.sv
`timescale 1ns/1ps
module sample_sequencer
    import seqr_pkg::*;
#(
    parameter int LIST_LEN       = 8,
    parameter int CH_W           = 3,
    parameter int SMP_W          = 12,
    parameter int FIFO_DEPTH     = 32,
    parameter int DLY_W          = 8,
    parameter int SEL_W          = 2,
    parameter int PACE_STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_ack,
    input  logic [SMP_W-1:0] conv_code
);
    localparam int IDX_W  = $clog2(LIST_LEN);
    localparam int LIST_W = LIST_LEN * CH_W;
    localparam int WORD_W = CH_W + SMP_W;
    localparam int PW     = $clog2(FIFO_DEPTH);

    typedef struct packed {
        logic              cont;
        logic [LIST_W-1:0] list;
        logic [IDX_W-1:0]  last_idx;
        logic [DLY_W-1:0]  dly;
        logic [SEL_W-1:0]  sel;
    } cfg_s;

    cfg_s c_d, c_q;
    logic wr_ctrl, start, stop, clr, pop;
    logic busy, pace_load, pace_done, push;
    logic [WORD_W-1:0] push_data, head;
    logic [PW:0] count;
    logic full, empty, ovf;
    logic unused_wdata;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign start   = wr_ctrl && reg_wdata[C_START] && reg_wdata[C_EN];
    assign stop    = wr_ctrl && (reg_wdata[C_STOP] || !reg_wdata[C_EN]);
    assign clr     = wr_ctrl && reg_wdata[C_CLR];
    assign pop     = reg_rd && (reg_addr == ADDR_FIFO);
    assign unused_wdata = ^reg_wdata;

    always_comb begin
        c_d = c_q;
        if (wr_ctrl)
            c_d.cont = reg_wdata[C_CONT];
        if (reg_wr && reg_addr == ADDR_LIST) begin
            c_d.list     = reg_wdata[LIST_W-1:0];
            c_d.last_idx = reg_wdata[L_LAST +: IDX_W];
        end
        if (reg_wr && reg_addr == ADDR_PACE) begin
            c_d.dly = reg_wdata[DLY_W-1:0];
            c_d.sel = reg_wdata[P_SEL +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[S_BUSY]       = busy;
                reg_rdata[S_FULL]       = full;
                reg_rdata[S_EMPTY]      = empty;
                reg_rdata[S_OVF]        = ovf;
                reg_rdata[S_CNT +: PW]  = count[PW-1:0];
            end
            ADDR_LIST: begin
                reg_rdata[LIST_W-1:0]      = c_q.list;
                reg_rdata[L_LAST +: IDX_W] = c_q.last_idx;
            end
            ADDR_PACE: begin
                reg_rdata[DLY_W-1:0]     = c_q.dly;
                reg_rdata[P_SEL +: SEL_W] = c_q.sel;
            end
            default: reg_rdata[WORD_W-1:0] = empty ? '0 : head;
        endcase
    end

    seq_ctrl #(.LIST_LEN(LIST_LEN), .CH_W(CH_W), .SMP_W(SMP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cont(c_q.cont),
        .list(c_q.list), .last_idx(c_q.last_idx), .pace_done(pace_done),
        .conv_ack(conv_ack), .conv_code(conv_code), .conv_req(conv_req),
        .conv_chan(conv_chan), .busy(busy), .pace_load(pace_load),
        .push(push), .push_data(push_data)
    );

    seq_pace #(.DLY_W(DLY_W), .SEL_W(SEL_W), .STEP(PACE_STEP_LOG2)) u_pace (
        .clk(clk), .rst_n(rst_n), .load(pace_load), .dly(c_q.dly),
        .sel(c_q.sel), .done(pace_done)
    );

    seq_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .clr_ovf(clr), .head(head), .count(count),
        .full(full), .empty(empty), .ovf(ovf)
    );

    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !reg_wdata[C_EN] && !busy) |=> (!busy && !conv_req));
    p_full_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, empty}));
endmodule

// File: tb/tb_sample_sequencer.sv
`timescale 1ns/1ps
module tb_sample_sequencer;
    localparam int DEPTH = 8;
    localparam int STEP  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_req;
    logic [2:0]  conv_chan;
    logic        conv_ack = 1'b0;
    logic [11:0] conv_code = '0;

    sample_sequencer #(.FIFO_DEPTH(DEPTH), .PACE_STEP_LOG2(STEP)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_ack(conv_ack),
        .conv_code(conv_code)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int acks = 0, lat = 0, wait_cnt = 0;
    int last_ack_cyc = -1, last_gap = 0;
    int model_cnt = 0;
    logic prev_req = 1'b0;
    logic [11:0] seed = 12'h155;
    logic [2:0]  exp_chan[$];
    logic [14:0] sb[$];

    always @(posedge clk) cyc++;

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // converter model and scoreboard driver
    initial begin
        forever begin
            @(negedge clk);
            if (conv_ack) begin
                conv_ack = 1'b0;
            end else if (conv_req) begin
                if (!prev_req && last_ack_cyc >= 0)
                    last_gap = cyc - last_ack_cyc;
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    if (exp_chan.size() == 0) begin
                        chk("R3 unexpected request", conv_chan, 8);
                    end else begin
                        chk("R3 channel order", conv_chan, exp_chan.pop_front());
                    end
                    seed = seed + 12'd37;
                    conv_code = seed;
                    if (model_cnt < DEPTH) begin
                        sb.push_back({conv_chan, seed});
                        model_cnt++;
                    end
                    conv_ack = 1'b1;
                    last_ack_cyc = cyc;
                    acks++;
                end
            end
            prev_req = conv_req;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic pop_chk(input string rq);
        logic [31:0] d;
        int exp;
        rd(2'd3, d);
        exp = (sb.size() == 0) ? 0 : int'(sb.pop_front());
        if (model_cnt > 0) model_cnt--;
        chk(rq, d, exp);
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd0, d);
            if (!d[0]) break;
        end
    endtask

    logic [31:0] st;
    int base;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, st);
        chk("R1 busy", st[0], 0);
        chk("R1 empty", st[4], 1);
        chk("R1 full/ovf/count", {st[3], st[5], st[10:8]}, 0);
        chk("R1 conv_req", conv_req, 0);
        chk("R6 busy upper bits", st[2:1], 0);

        // R2 start without enable
        wr(2'd1, (32'd0 << 24) | 32'd5);
        wr(2'd0, 32'h4);
        repeat (5) @(negedge clk);
        rd(2'd0, st);
        chk("R2 start ignored busy", st[0], 0);
        chk("R2 no request", acks, 0);

        // R3/R5/R9: one pass, list 5,2,7,0
        wr(2'd2, 32'h0);
        wr(2'd1, (32'd3 << 24) | (32'd0 << 9) | (32'd7 << 6) | (32'd2 << 3) | 32'd5);
        exp_chan = '{3'd5, 3'd2, 3'd7, 3'd0};
        wr(2'd0, 32'h5);
        rd(2'd0, st);
        chk("R6 busy during run", st[0], 1);
        wait_idle();
        chk("R3 pass length", acks, 4);
        chk("R9 gap D=0 S=0", last_gap, 2);
        rd(2'd0, st);
        chk("R6 count field", st[10:8], 4);
        for (int i = 0; i < 4; i++) pop_chk("R5 tagged word");
        // R7 empty read
        rd(2'd3, st);
        chk("R7 empty read value", st, 0);
        rd(2'd0, st);
        chk("R7 empty count", st[10:8], 0);
        chk("R7 empty flag", st[4], 1);

        // R9 pace D=2 S=2 -> 12 cycles
        wr(2'd2, (32'd2 << 8) | 32'd2);
        wr(2'd1, (32'd1 << 24) | (32'd6 << 3) | 32'd1);
        exp_chan = '{3'd1, 3'd6};
        wr(2'd0, 32'h5);
        wait_idle();
        chk("R9 gap D=2 S=2", last_gap, 13);
        for (int i = 0; i < 2; i++) pop_chk("R5 pace run word");

        // R4/R11/R10 continuous, restart attempt, stop during wait
        wr(2'd2, (32'd1 << 8) | 32'd9);
        wr(2'd1, (32'd1 << 24) | (32'd6 << 3) | 32'd3);
        exp_chan = '{3'd3, 3'd6, 3'd3, 3'd6, 3'd3};
        base = acks;
        wr(2'd0, 32'h7);
        wait (acks == base + 1);
        wr(2'd0, 32'h7);
        wait (acks == base + 5);
        wr(2'd0, 32'hB);
        rd(2'd0, st);
        chk("R10 stop in wait idle", st[0], 0);
        repeat (60) @(negedge clk);
        chk("R4 continuous count", acks, base + 5);
        chk("R11 restart ignored", exp_chan.size(), 0);
        for (int i = 0; i < 5; i++) pop_chk("R4 continuous word");

        // R10 enable cleared during wait
        wr(2'd1, (32'd1 << 24) | (32'd5 << 3) | 32'd2);
        exp_chan = '{3'd2};
        base = acks;
        wr(2'd0, 32'h7);
        wait (acks == base + 1);
        wr(2'd0, 32'h2);
        repeat (60) @(negedge clk);
        rd(2'd0, st);
        chk("R10 enable clear idle", st[0], 0);
        chk("R10 enable clear count", acks, base + 1);
        pop_chk("R10 enable clear word");

        // R10 stop during outstanding request
        lat = 10;
        wr(2'd1, (32'd1 << 24) | (32'd1 << 3) | 32'd4);
        exp_chan = '{3'd4};
        base = acks;
        wr(2'd0, 32'h7);
        wait (conv_req);
        wr(2'd0, 32'hB);
        wait_idle();
        repeat (60) @(negedge clk);
        chk("R10 stop in request completes", acks, base + 1);
        rd(2'd0, st);
        chk("R10 stored count", st[10:8], 1);
        pop_chk("R10 completed word");
        lat = 0;

        // R8 fill and overflow
        wr(2'd2, 32'h0);
        wr(2'd1, (32'd7 << 24) | 32'hFAC688);
        exp_chan = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h5);
        wait_idle();
        rd(2'd0, st);
        chk("R8 full flag", st[3], 1);
        chk("R6 count wraps at full", st[10:8], 0);
        chk("R8 no ovf yet", st[5], 0);
        wr(2'd1, (32'd2 << 24) | 32'hFAC688);
        exp_chan = '{3'd0, 3'd1, 3'd2};
        wr(2'd0, 32'h5);
        wait_idle();
        rd(2'd0, st);
        chk("R8 ovf set", st[5], 1);
        for (int i = 0; i < 8; i++) pop_chk("R8 kept word");
        rd(2'd0, st);
        chk("R8 ovf sticky", st[5], 1);
        chk("R8 empty after drain", st[4], 1);
        wr(2'd0, 32'h10);
        rd(2'd0, st);
        chk("R8 ovf cleared", st[5], 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule